// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written over a plain one-cycle write strobe into framed characters on an asynchronous serial line. Bytes wait in a 16-entry queue. A programmable divisor turns the reference clock into an enable pulse at sixteen times the bit rate. Every bit, and every fraction of a stop bit, is timed by counting those pulses.

Each character is framed as follows: the line idles high, a low start bit comes first, then 5 to 8 data bits least significant bit first, then an optional parity bit, then a high stop interval of 1, 1.5 or 2 bit times. When more data is queued, the next start bit follows the stop interval with no gap. The line can be forced low for break signalling. Transmission can also be paused through a clear-to-send input, which is consulted only between characters. Two status outputs show whether the queue is empty and whether the whole transmitter is idle.

The framing settings are captured when a character starts, so a setting changed during a character applies only to the characters that follow it.

Top module: `uart_tx_fifo`

## Requirements
- R1: One bit lasts 16*D reference clock cycles, where D is the value of `divisor`; a `divisor` of 0 behaves as 1.
- R2: The line idles high (1). A frame starts with one low start bit, followed by the data bits least significant bit first. The number of data bits is `char_len`+5 (code 0 gives 5 bits, code 3 gives 8 bits).
- R3: When `parity_en`=1, one parity bit follows the data. With `parity_odd`=0 the number of ones in the data and parity bits together is even; with `parity_odd`=1 it is odd. When `parity_en`=0 no parity bit is sent.
- R4: `stop_long`=0 gives a stop interval of 16 ticks. `stop_long`=1 gives 24 ticks (1.5 bits) when the character has 5 bits, and 32 ticks (2 bits) for any other length. The line is high throughout the stop interval.
- R5: The queue holds up to 16 bytes and `fifo_full` is 1 while it does. A write made while the queue is full is dropped.
- R6: When another byte is already queued and sending is allowed, its start bit begins on the tick that ends the previous stop interval. The distance between consecutive falling edges is then exactly the frame length in ticks times D.
- R7: While `break_en`=1, `txd` is low. Once `break_en` returns to 0, `txd` shows the normal line level again.
- R8: While `auto_cts_en`=1 and `cts`=0, no new frame starts, but a frame already in progress completes. When `auto_cts_en`=0, `cts` has no effect.
- R9: `fifo_empty` is 1 when the queue holds no byte. `tx_empty` is 1 only when the queue is empty and no frame, including its stop interval, is in progress.
- R10: After reset `txd`=1, `fifo_empty`=1, `tx_empty`=1 and `fifo_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | 16 | Clock divisor for the 16x tick; 0 acts as 1 |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Add a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_long | input | 1 | 0: 1 stop bit; 1: 1.5 stop bits (5-bit characters) or 2 stop bits |
| break_en | input | 1 | Force the line low |
| auto_cts_en | input | 1 | Gate frame starts with `cts` |
| cts | input | 1 | Clear to send, active high |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue is empty |
| tx_empty | output | 1 | Queue is empty and the line is idle |
| txd | output | 1 | Serial output |

## Verification
The assertions assume that `cts` and all other inputs are synchronous to `clk`, and that the framing inputs are changed only while `tx_empty` is 1. The assertions on the queue count assume nothing about the write rate, so writes into a full queue are permitted. The stimulus changes configuration only after waiting for `tx_empty`, and it drives every input on the falling clock edge. Random bursts keep the divisor between 0 and 3, so that many frames fit in a run. Directed cases cover divisor 0, overfilling the queue while clear-to-send is held off, dropping clear-to-send in the middle of a character, and break.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int DIVW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] divisor,
  input  logic [1:0]      char_len,
  input  logic            parity_en,
  input  logic            parity_odd,
  input  logic            stop_long,
  input  logic            break_en,
  input  logic            auto_cts_en,
  input  logic            cts,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic            fifo_full,
  output logic            fifo_empty,
  output logic            tx_empty,
  output logic            txd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          wr_ok, pop;

  logic [DIVW-1:0] divc, div_last;
  logic            tick;

  st_t           state;
  logic [5:0]    sub, stop_last;
  logic [2:0]    bitn, nbits;
  logic [DW-1:0] shreg;
  logic          par_on, par_bit, can_go, start_now, line;

  assign fifo_full  = (count == CW'(DEPTH));
  assign fifo_empty = (count == '0);
  assign wr_ok      = wr_en && !fifo_full;
  assign pop        = start_now;

  always_ff @(posedge clk) if (wr_ok) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)   rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end

  assign div_last = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick     = (divc >= div_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) divc <= '0;
    else        divc <= tick ? '0 : divc + 1'b1;

  assign can_go    = !fifo_empty && (!auto_cts_en || cts);
  assign start_now = tick && can_go &&
                     (state == S_IDLE || (state == S_STOP && sub == stop_last));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; sub <= '0; bitn <= '0; nbits <= '0; shreg <= '0;
      par_on <= 1'b0; par_bit <= 1'b0; stop_last <= 6'd15;
    end else if (start_now) begin
      state     <= S_START;
      sub       <= '0;
      bitn      <= '0;
      shreg     <= mem[rptr];
      nbits     <= {1'b1, char_len};
      par_on    <= parity_en;
      par_bit   <= ^(mem[rptr] & (8'hFF >> (2'd3 - char_len))) ^ parity_odd;
      stop_last <= !stop_long ? 6'd15 : (char_len == 2'd0) ? 6'd23 : 6'd31;
    end else if (tick) begin
      case (state)
        S_START: begin
          sub <= (sub == 6'd15) ? '0 : sub + 1'b1;
          if (sub == 6'd15) state <= S_DATA;
        end
        S_DATA: begin
          sub <= (sub == 6'd15) ? '0 : sub + 1'b1;
          if (sub == 6'd15) begin
            shreg <= shreg >> 1;
            bitn  <= bitn + 1'b1;
            if (bitn == nbits) state <= par_on ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          sub <= (sub == 6'd15) ? '0 : sub + 1'b1;
          if (sub == 6'd15) state <= S_STOP;
        end
        S_STOP: begin
          if (sub == stop_last) begin
            state <= S_IDLE;
            sub   <= '0;
          end else sub <= sub + 1'b1;
        end
        default: sub <= '0;
      endcase
    end

  always_comb
    case (state)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = par_bit;
      default: line = 1'b1;
    endcase

  assign txd      = line && !break_en;
  assign tx_empty = fifo_empty && (state == S_IDLE);

  a_r1_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));
  a_r2_sub_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (sub < 6'd16));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !pop) |=> (count == $past(count)));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_cts_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_START && tick && auto_cts_en && !cts) |=> (state != S_START));
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: tb/uart_tx_fifo_bench.sv
module uart_tx_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] char_len = 2'd3;
  logic parity_en = 0, parity_odd = 0, stop_long = 0, break_en = 0;
  logic auto_cts_en = 0, cts = 1, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic fifo_full, fifo_empty, tx_empty, txd;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] bytes [0:31];

  uart_tx_fifo u_uart_tx_fifo (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int deff();
    return (divisor == 0) ? 1 : int'(divisor);
  endfunction
  function automatic int nbits();
    return int'(char_len) + 5;
  endfunction
  function automatic int stop_ticks();
    return !stop_long ? 16 : (char_len == 0 ? 24 : 32);
  endfunction
  function automatic int frame_ticks();
    return 16 * (1 + nbits() + int'(parity_en)) + stop_ticks();
  endfunction
  function automatic logic exp_par(input logic [7:0] d);
    return ^(d & (8'hFF >> (3 - char_len))) ^ parity_odd;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_fall(output int at);
    logic last = 1;
    forever begin
      @(negedge clk);
      if (last && !txd) break;
      last = txd;
    end
    at = cyc;
  endtask

  task automatic rx_frame(input logic [7:0] d, output int at);
    logic [7:0] got = '0;
    logic [7:0] mask = 8'hFF >> (3 - char_len);
    int db = deff();
    wait_fall(at);
    repeat (8 * db) @(negedge clk);
    chk("R2 start bit low", txd, 0);
    for (int i = 0; i < nbits(); i++) begin
      repeat (16 * db) @(negedge clk);
      got[i] = txd;
    end
    chk("R2 data LSB first", got, d & mask);
    if (parity_en) begin
      repeat (16 * db) @(negedge clk);
      chk("R3 parity bit", txd, exp_par(d));
    end
    repeat (16 * db) @(negedge clk);
    chk("R4 stop level high", txd, 1);
  endtask

  task automatic burst(input int n, input string req);
    int prev = 0, at = 0;
    fork
      for (int i = 0; i < n; i++) push(bytes[i]);
      for (int i = 0; i < n; i++) begin
        rx_frame(bytes[i], at);
        if (i > 0) chk(req, at - prev, frame_ticks() * deff());
        prev = at;
      end
    join
    while (!tx_empty) @(negedge clk);
  endtask

  initial begin
    int at = 0, prev = 0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R10 txd idle", txd, 1);
    chk("R10 fifo_empty", fifo_empty, 1);
    chk("R10 tx_empty", tx_empty, 1);
    chk("R10 fifo_full", fifo_full, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: divisor 0 behaves as 1, 8N1
    divisor = 0; char_len = 3;
    bytes[0] = 8'hA5; bytes[1] = 8'h3C;
    burst(2, "R1 spacing divisor0");
    // R1/R3/R4: divisor 3, 7 bits, odd parity, 2 stop
    divisor = 3; char_len = 2; parity_en = 1; parity_odd = 1; stop_long = 1;
    bytes[0] = 8'h7F; bytes[1] = 8'h01; bytes[2] = 8'h55;
    burst(3, "R4 spacing two stop");
    // R4: 1.5 stop with 5 bits, even parity
    divisor = 2; char_len = 0; parity_odd = 0;
    bytes[0] = 8'h1F; bytes[1] = 8'h0A;
    burst(2, "R4 spacing 1.5 stop");

    // R9 status during and after a single frame
    divisor = 1; char_len = 3; parity_en = 0; stop_long = 0;
    fork
      push(8'h96);
      begin
        wait_fall(at);
        chk("R9 fifo_empty after start", fifo_empty, 1);
        chk("R9 tx_empty busy", tx_empty, 0);
      end
    join
    repeat (16 * 9 + 8) @(negedge clk);
    chk("R9 tx_empty in stop", tx_empty, 0);
    repeat (10) @(negedge clk);
    chk("R9 tx_empty after stop", tx_empty, 1);

    // R7 break
    break_en = 1;
    repeat (40) @(negedge clk);
    chk("R7 break low", txd, 0);
    break_en = 0;
    @(negedge clk);
    chk("R7 break released", txd, 1);

    // R5/R8: overfill while held off by CTS
    auto_cts_en = 1; cts = 0;
    for (int i = 0; i < 17; i++) begin
      bytes[i] = 8'(i * 13 + 7);
      push(bytes[i]);
    end
    repeat (400) @(negedge clk);
    chk("R8 held by cts", txd, 1);
    chk("R5 fifo_full", fifo_full, 1);
    chk("R8 fifo not drained", fifo_empty, 0);
    cts = 1;
    for (int i = 0; i < 16; i++) begin
      rx_frame(bytes[i], at);
      if (i > 0) chk("R6 back to back", at - prev, frame_ticks() * deff());
      prev = at;
    end
    repeat (300) @(negedge clk);
    chk("R5 write when full dropped", tx_empty, 1);
    chk("R5 no extra frame", txd, 1);

    // R8: CTS dropped during a character
    push(8'hC3); push(8'h5A);
    fork
      rx_frame(8'hC3, at);
      begin
        while (txd) @(negedge clk);
        cts = 0;
      end
    join
    repeat (400) @(negedge clk);
    chk("R8 next frame held", txd, 1);
    chk("R8 byte still queued", fifo_empty, 0);
    cts = 1;
    rx_frame(8'h5A, at);
    while (!tx_empty) @(negedge clk);

    // R8: cts ignored when auto gating is off
    auto_cts_en = 0; cts = 0;
    bytes[0] = 8'h81; bytes[1] = 8'h7E;
    burst(2, "R8 cts ignored spacing");
    cts = 1;

    // random bursts
    for (int k = 0; k < 10; k++) begin
      divisor = 16'($urandom_range(0, 3));
      char_len = 2'($urandom_range(0, 3));
      parity_en = 1'($urandom_range(0, 1));
      parity_odd = 1'($urandom_range(0, 1));
      stop_long = 1'($urandom_range(0, 1));
      auto_cts_en = 1'($urandom_range(0, 1));
      cts = auto_cts_en ? 1'b1 : 1'($urandom_range(0, 1));
      for (int i = 0; i < 4; i++) bytes[i] = 8'($urandom);
      burst($urandom_range(1, 4), "R6 random spacing");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule